// File: doc/BRIEF.md
# Bus-Addressed Four-Digit Segment Latch

This block is the write side of a four-digit seven-segment display. A host puts a 4-bit character code and a 2-bit digit address on its inputs and pulls two active-low selects low together. While both are low, the code and address are held in an input buffer. When either select goes high again, the buffered code is turned into a seven-segment pattern and stored in the latch of the digit that the buffered address names. The four latches drive 28 segment outputs until the next write to that digit or the next reset.

Both selects are sampled on a system clock. A write commits exactly once, on the first clock where the pair stops being jointly low, even if both selects rise together or rise one after the other. A parameter chooses the character set: full hexadecimal, or a reduced set with the decimal digits and six special symbols.

Top module: `seg4_bus_latch`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all 28 segment outputs to 0, so every digit is blank.
- R2: The code and address are taken into the buffer only on clock edges where both cs_a_n and cs_b_n are low. Values presented while only one select, or neither, is low are never written to a digit. If the code changes while both are low, the value of the last jointly-low clock is used.
- R3: A commit happens on the first clock edge where both selects were low at the previous edge and at least one is high now. It happens once per write whether cs_a_n rises first, cs_b_n rises first or both rise together, and it changes at most one digit.
- R4: Address 0 writes digit 4 (the most significant digit, seg_o[27:21]), address 1 writes digit 3 (seg_o[20:14]), address 2 writes digit 2 (seg_o[13:7]) and address 3 writes digit 1 (the least significant digit, seg_o[6:0]).
- R5: din is positive-true binary, with din[0] weighing one and din[3] weighing eight. In each 7-bit digit field, bit 0 is segment a (top), going clockwise through b, c, d, e and f, and bit 6 is segment g (middle). A set bit lights the segment.
- R6: With CODE_B = 0, codes 0 to 15 give hexadecimal characters: 0x3F,0x06,0x5B,0x4F,0x66,0x6D,0x7D,0x07,0x7F,0x6F,0x77,0x7C,0x39,0x5E,0x79,0x71.
- R7: With CODE_B = 1, codes 0 to 9 give the same decimal digits as R6. Codes 10 to 15 give dash 0x40, E 0x79, H 0x76, L 0x38, P 0x73 and blank 0x00, in that order.
- R8: The segment outputs hold their value on every clock edge that is not a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| din | input | 4 | Character code |
| addr | input | 2 | Digit address (0 selects the most significant digit) |
| seg_o | output | 28 | Segment bits, digit 1 at [6:0] up to digit 4 at [27:21] |

## Verification
The bench releases the selects in all three orders. A design that keyed the commit to one select, or to each rising edge, would miss writes or write twice. It changes the code and address right after the release, and it pulses one select alone with a different code. A design that buffered outside the jointly-low window would show the wrong character or write a stray digit. Writes of every code to every address, on both decode variants, show a reversed address map as the wrong digit changing, and a wrong table entry as a wrong segment pattern.

// File: rtl/seg4_bus_latch.sv
module seg4_bus_latch #(
  parameter bit CODE_B = 1'b0,
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cs_a_n,
  input  logic                            cs_b_n,
  input  logic [3:0]                      din,
  input  logic [ADDR_W-1:0]               addr,
  output logic [(1<<ADDR_W)*7-1:0]        seg_o
);
  localparam int SEG_W  = 7;
  localparam int DIGITS = 1 << ADDR_W;
  localparam int OUT_W  = DIGITS * SEG_W;

  function automatic logic [SEG_W-1:0] decode(input logic [3:0] c);
    case (c)
      4'd0:  decode = 7'h3F;
      4'd1:  decode = 7'h06;
      4'd2:  decode = 7'h5B;
      4'd3:  decode = 7'h4F;
      4'd4:  decode = 7'h66;
      4'd5:  decode = 7'h6D;
      4'd6:  decode = 7'h7D;
      4'd7:  decode = 7'h07;
      4'd8:  decode = 7'h7F;
      4'd9:  decode = 7'h6F;
      4'd10: decode = CODE_B ? 7'h40 : 7'h77;
      4'd11: decode = CODE_B ? 7'h79 : 7'h7C;
      4'd12: decode = CODE_B ? 7'h76 : 7'h39;
      4'd13: decode = CODE_B ? 7'h38 : 7'h5E;
      4'd14: decode = CODE_B ? 7'h73 : 7'h79;
      default: decode = CODE_B ? 7'h00 : 7'h71;
    endcase
  endfunction

  logic              sel_now, sel_q, commit;
  logic [3:0]        buf_d;
  logic [ADDR_W-1:0] buf_a;
  logic [SEG_W-1:0]  pattern;

  assign sel_now = ~cs_a_n & ~cs_b_n;
  assign commit  = sel_q & ~sel_now;
  assign pattern = decode(buf_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      buf_d <= '0;
      buf_a <= '0;
    end else begin
      sel_q <= sel_now;
      if (sel_now) begin
        buf_d <= din;
        buf_a <= addr;
      end
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst)
        seg_o[g*SEG_W +: SEG_W] <= '0;
      else if (commit && buf_a == ADDR_W'(DIGITS-1-g))
        seg_o[g*SEG_W +: SEG_W] <= pattern;
    end
  end

  logic [OUT_W-1:0]  seg_prev;
  logic [DIGITS-1:0] fld_chg;

  always_ff @(posedge clk) begin
    if (rst) seg_prev <= '0;
    else     seg_prev <= seg_o;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_chg
    assign fld_chg[g] = seg_o[g*SEG_W +: SEG_W] != seg_prev[g*SEG_W +: SEG_W];
  end

  p_reset_blank_r1: assert property (@(posedge clk) rst |=> seg_o == '0);

  p_buffer_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_now |=> ($stable(buf_d) && $stable(buf_a)));

  p_one_digit_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fld_chg));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_q || sel_now) |=> $stable(seg_o));
endmodule

// File: tb/test_seg4_bus_latch.sv
module test_seg4_bus_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_a_n = 1'b1;
  logic        cs_b_n = 1'b1;
  logic [3:0]  din = '0;
  logic [1:0]  addr = '0;
  logic [27:0] seg_h, seg_b;
  logic [27:0] exp_h, exp_b;
  int          errors = 0;
  int          checks = 0;
  int unsigned seed = 32'd7211;

  always #2 clk = ~clk;

  seg4_bus_latch #(.CODE_B(1'b0)) i_seg4_bus_latch (
    .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .din(din), .addr(addr), .seg_o(seg_h));

  seg4_bus_latch #(.CODE_B(1'b1)) i_seg4_bus_latch_b (
    .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .din(din), .addr(addr), .seg_o(seg_b));

  function automatic logic [6:0] ref_hex(input logic [3:0] c);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[c];
  endfunction

  function automatic logic [6:0] ref_cb(input logic [3:0] c);
    logic [6:0] t [6] = '{7'h40,7'h79,7'h76,7'h38,7'h73,7'h00};
    return (c < 4'd10) ? ref_hex(c) : t[c - 4'd10];
  endfunction

  task automatic check(input string req);
    checks++;
    if (seg_h !== exp_h) begin
      errors++;
      $display("FAIL %s hex: actual %h expected %h", req, seg_h, exp_h);
    end
    checks++;
    if (seg_b !== exp_b) begin
      errors++;
      $display("FAIL %s codeb: actual %h expected %h", req, seg_b, exp_b);
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [3:0] d);
    int idx = 3 - int'(a);
    exp_h[idx*7 +: 7] = ref_hex(d);
    exp_b[idx*7 +: 7] = ref_cb(d);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] d,
                          input int mode, input string req);
    @(negedge clk);
    din = d; addr = a; cs_a_n = 1'b0; cs_b_n = 1'b0;
    @(negedge clk);
    case (mode)
      0: cs_a_n = 1'b1;
      1: cs_b_n = 1'b1;
      default: begin cs_a_n = 1'b1; cs_b_n = 1'b1; end
    endcase
    din = 4'($urandom(seed)); addr = 2'($urandom(seed));
    @(negedge clk);
    cs_a_n = 1'b1; cs_b_n = 1'b1;
    model_write(a, d);
    check(req);
    @(negedge clk);
    check({req, " single commit R3"});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_h = '0; exp_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset blank");

    // R4 address map, R5/R6/R7 every code at every address, all release orders
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 16; c++)
        do_write(2'(a), 4'(c), c % 3, "R4 R5 R6 R7 directed");

    // R3 both selects rise together, then one after the other
    do_write(2'd1, 4'd12, 2, "R3 both rise");
    do_write(2'd2, 4'd10, 0, "R3 a first");
    do_write(2'd2, 4'd11, 1, "R3 b first");

    // R2 a single select low must not write
    @(negedge clk);
    din = 4'd8; addr = 2'd3; cs_a_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_a_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 single select ignored");
    din = 4'd8; addr = 2'd0; cs_b_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_b_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 other select ignored");

    // R2 last jointly-low value wins
    @(negedge clk);
    din = 4'd1; addr = 2'd0; cs_a_n = 1'b0; cs_b_n = 1'b0;
    @(negedge clk);
    din = 4'd14; addr = 2'd3;
    @(negedge clk);
    cs_b_n = 1'b1; din = 4'd5; addr = 2'd1;
    @(negedge clk);
    cs_a_n = 1'b1;
    model_write(2'd3, 4'd14);
    check("R2 last buffered value");

    // R8 idle cycles with changing data
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      din = 4'($urandom(seed)); addr = 2'($urandom(seed));
    end
    check("R8 hold when idle");

    // random writes
    for (int i = 0; i < 300; i++)
      do_write(2'($urandom(seed)), 4'($urandom(seed)),
               int'($urandom(seed) % 3), "R6 R7 random");

    // R1 reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_h = '0; exp_b = '0;
    check("R1 reset after writes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule